// File: doc/BRIEF.md
# UART Bit-Timing Tick Generator

This block produces the two timing strobes that a UART's serial shift logic needs. One marks the end of each transmitted bit. The other marks the instant at which the receiver should sample the line.

A programmable prescaler divides the system clock into prescaled ticks. An in-bit tick counter then groups those ticks into bit periods. Two modes set the grouping:

- **Standard mode** uses a fixed 16 ticks per bit and samples mid-bit.
- **Fast mode** takes the bit length and the sampling tick from software registers, so high baud rates can be reached with fine divisor resolution.

Software programs the block through a small byte-wide write port. The divisor bytes are reachable only while a latch-access control bit is set.

The receive path pulses `rx_start` when it detects a start-bit edge. The block then restarts its bit phase so that samples line up with the incoming frame. Newly written timing settings are held in shadow registers and applied at the next bit boundary.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high both strobes stay low. After `rst` falls, the defaults apply: standard mode and divisor 1. Counting the cycle just after the falling edge as cycle 0, the first `rx_smp_stb` is in cycle 7 and the first `tx_bit_stb` is in cycle 15.
- R2: A mode register value (address 3, bits [1:0]) other than 3 selects standard mode. In standard mode a bit lasts 16 prescaled ticks and `rx_smp_stb` fires on the tick whose 0-based in-bit index is 7. The programmed sample point and bit-length registers have no effect in this mode.
- R3: Mode value 3 selects fast mode. A bit then lasts (span+1) prescaled ticks, with span at address 4. `rx_smp_stb` fires on the tick whose in-bit index equals the sample point at address 5.
- R4: The prescaled tick occurs once every D clocks. D is the 16-bit divisor, with its low byte at address 1 and its high byte at address 2.
- R5: Bit 7 of the control register (address 0) enables divisor access. Writes to address 1 or 2 while that bit is clear are ignored.
- R6: A divisor of 0 behaves as a divisor of 1.
- R7: A pulse on `rx_start` clears the prescaler and the in-bit index. Counting from the cycle after the pulse as cycle 0, the sample strobe falls in cycle sp*D+D-1 and the bit-end strobe in cycle L*D+D-1, where L is the last in-bit index (15 in standard mode).
- R8: `tx_bit_stb` is a single-cycle pulse issued on the tick where the in-bit index wraps from its last value to 0. Consecutive pulses are (L+1)*D cycles apart.
- R9: Divisor, mode, span and sample-point writes take effect only at a bit boundary (a `tx_bit_stb` cycle). A bit already in progress keeps its old timing, and `rx_start` does not apply pending settings.
- R10: In a cycle where `rx_start` is high, both strobes are held low, even if a tick would have produced one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 divisor low, 2 divisor high, 3 mode, 4 span, 5 sample point) |
| wr_data | input | 8 | Register write data |
| rx_start | input | 1 | Start-edge detected pulse from the receiver |
| tx_bit_stb | output | 1 | Bit-boundary strobe for the transmitter |
| rx_smp_stb | output | 1 | Sample strobe for the receiver |

## Verification
A start-edge pulse and a bit-boundary tick can land in the same clock cycle, with the phase restart competing against the wrap that would emit a strobe and apply pending settings. The bench counts cycles from a start pulse to the cycle in which the bit-end strobe is due, and raises `rx_start` exactly there. It then requires the strobe to stay low in that cycle, and requires the following sample strobe to be timed from the new start rather than from the suppressed boundary. A second overlap, a register write during a running bit, is judged by timing the current bit with the old divisor and the next bit with the new one.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int REG_AW = 3;
   typedef logic [REG_AW-1:0] reg_addr_t;

   // register map
   localparam reg_addr_t A_CTRL  = 3'd0;
   localparam reg_addr_t A_DIVLO = 3'd1;
   localparam reg_addr_t A_DIVHI = 3'd2;
   localparam reg_addr_t A_MODE  = 3'd3;
   localparam reg_addr_t A_SPAN  = 3'd4;
   localparam reg_addr_t A_SMPPT = 3'd5;

   localparam int         CTRL_LATCH_BIT = 7;
   localparam logic [1:0] MODE_FAST      = 2'd3;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
   import baud_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int CNT_W    = 8,
   parameter int SPAN_RST = 15,
   parameter int SP_RST   = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  reg_addr_t        wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             commit,
   output logic [DIV_W-1:0] act_div,
   output logic             act_fast,
   output logic [CNT_W-1:0] act_span,
   output logic [CNT_W-1:0] act_sp
);
   localparam int HI_W = DIV_W - 8;

   logic             latch_en;
   logic [DIV_W-1:0] div_sh;
   logic [1:0]       mode_sh;
   logic [CNT_W-1:0] span_sh;
   logic [CNT_W-1:0] sp_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         latch_en <= 1'b0;
         div_sh   <= DIV_W'(1);
         mode_sh  <= 2'd0;
         span_sh  <= CNT_W'(SPAN_RST);
         sp_sh    <= CNT_W'(SP_RST);
         act_div  <= DIV_W'(1);
         act_fast <= 1'b0;
         act_span <= CNT_W'(SPAN_RST);
         act_sp   <= CNT_W'(SP_RST);
      end else begin
         if (wr_en) begin
            case (wr_addr)
               A_CTRL:  latch_en <= wr_data[CTRL_LATCH_BIT];
               A_DIVLO: if (latch_en) div_sh[7:0] <= wr_data;
               A_DIVHI: if (latch_en) div_sh[DIV_W-1:8] <= wr_data[HI_W-1:0];
               A_MODE:  mode_sh <= wr_data[1:0];
               A_SPAN:  span_sh <= wr_data[CNT_W-1:0];
               A_SMPPT: sp_sh   <= wr_data[CNT_W-1:0];
               default: ;
            endcase
         end
         if (commit) begin
            act_div  <= div_sh;
            act_fast <= (mode_sh == MODE_FAST);
            act_span <= span_sh;
            act_sp   <= sp_sh;
         end
      end
   end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic [DIV_W-1:0] pre_cnt
);
   logic [DIV_W-1:0] div_eff;
   logic             at_end;

   assign div_eff = (div == '0) ? DIV_W'(1) : div;
   assign at_end  = (pre_cnt == div_eff - DIV_W'(1));
   assign tick    = !rst && at_end;

   always_ff @(posedge clk) begin
      if (rst || clear)  pre_cnt <= '0;
      else if (at_end)   pre_cnt <= '0;
      else               pre_cnt <= pre_cnt + DIV_W'(1);
   end
endmodule

// File: rtl/baud_bit_phase.sv
module baud_bit_phase #(
   parameter int CNT_W      = 8,
   parameter int LEGACY_OVS = 16,
   parameter int LEGACY_SMP = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             tick,
   input  logic             fast,
   input  logic [CNT_W-1:0] span,
   input  logic [CNT_W-1:0] smp_pt,
   output logic [CNT_W-1:0] bit_idx,
   output logic             wrap,
   output logic             smp
);
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] pick_idx;

   assign last_idx = fast ? span   : CNT_W'(LEGACY_OVS - 1);
   assign pick_idx = fast ? smp_pt : CNT_W'(LEGACY_SMP);
   assign wrap     = tick && (bit_idx == last_idx);
   assign smp      = tick && (bit_idx == pick_idx);

   always_ff @(posedge clk) begin
      if (rst || clear) bit_idx <= '0;
      else if (wrap)    bit_idx <= '0;
      else if (tick)    bit_idx <= bit_idx + CNT_W'(1);
   end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int CNT_W      = 8,
   parameter int LEGACY_OVS = 16,
   parameter int LEGACY_SMP = 7
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       rx_start,
   output logic       tx_bit_stb,
   output logic       rx_smp_stb
);
   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 9..16");
      end
      if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt
         $error("CNT_W must lie in 2..8");
      end
      if (LEGACY_OVS > (1 << CNT_W) || LEGACY_SMP >= LEGACY_OVS) begin : g_bad_ovs
         $error("standard oversampling does not fit CNT_W");
      end
   endgenerate

   logic [DIV_W-1:0] act_div;
   logic             act_fast;
   logic [CNT_W-1:0] act_span;
   logic [CNT_W-1:0] act_sp;
   logic [DIV_W-1:0] pre_cnt;
   logic [CNT_W-1:0] bit_idx;
   logic             tick, wrap, smp, commit;

   assign tx_bit_stb = wrap && !rx_start;
   assign rx_smp_stb = smp && !rx_start;
   assign commit     = tx_bit_stb;

   baud_cfg_regs #(
      .DIV_W(DIV_W), .CNT_W(CNT_W),
      .SPAN_RST(LEGACY_OVS - 1), .SP_RST(LEGACY_SMP)
   ) u_cfg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .commit(commit), .act_div(act_div),
      .act_fast(act_fast), .act_span(act_span), .act_sp(act_sp)
   );

   baud_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst(rst), .clear(rx_start), .div(act_div),
      .tick(tick), .pre_cnt(pre_cnt)
   );

   baud_bit_phase #(
      .CNT_W(CNT_W), .LEGACY_OVS(LEGACY_OVS), .LEGACY_SMP(LEGACY_SMP)
   ) u_phase (
      .clk(clk), .rst(rst), .clear(rx_start), .tick(tick),
      .fast(act_fast), .span(act_span), .smp_pt(act_sp),
      .bit_idx(bit_idx), .wrap(wrap), .smp(smp)
   );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
   parameter int DIV_W = 16,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             rx_start,
   input logic             tx_bit_stb,
   input logic             rx_smp_stb,
   input logic [DIV_W-1:0] pre_cnt,
   input logic [CNT_W-1:0] bit_idx,
   input logic [DIV_W-1:0] act_div
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> (!tx_bit_stb && !rx_smp_stb));

   // R10
   start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      rx_start |-> (!tx_bit_stb && !rx_smp_stb));

   // R7
   start_align_chk: assert property (@(posedge clk) disable iff (rst)
      rx_start |=> (pre_cnt == '0 && bit_idx == '0));

   // R8
   wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
      tx_bit_stb |=> (bit_idx == '0));

   // R9
   commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tx_bit_stb |=> $stable(act_div));

   // R6
   pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (act_div == '0) |-> (pre_cnt == '0));

   // R4
   pre_range_chk: assert property (@(posedge clk) disable iff (rst)
      (act_div != '0) |-> (pre_cnt < act_div));
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .rx_start(rx_start), .tx_bit_stb(tx_bit_stb),
   .rx_smp_stb(rx_smp_stb), .pre_cnt(pre_cnt), .bit_idx(bit_idx),
   .act_div(act_div)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rx_start = 1'b0;
   logic       tx_bit_stb, rx_smp_stb;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   baud_tick_gen u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rx_start(rx_start),
      .tx_bit_stb(tx_bit_stb), .rx_smp_stb(rx_smp_stb)
   );

   // vectors: divisor, mode, span, sample point, expected rx cycle, tx cycle, period
   localparam int NV = 8;
   localparam int V_DIV [NV] = '{1, 3, 2, 1, 0, 2, 257, 1};
   localparam int V_MODE[NV] = '{0, 0, 3, 3, 0, 1, 3,   3};
   localparam int V_SPAN[NV] = '{0, 0, 9, 4, 0, 5, 2,   0};
   localparam int V_SP  [NV] = '{0, 0, 4, 1, 0, 2, 0,   0};
   localparam int V_RK  [NV] = '{7, 23, 9, 1, 7, 15, 256, 0};
   localparam int V_TK  [NV] = '{15, 47, 19, 4, 15, 31, 770, 0};
   localparam int V_PER [NV] = '{16, 48, 20, 5, 16, 32, 771, 1};

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(int dv, int md, int sn, int sp);
      wr(0, 8'h80);
      wr(1, dv & 8'hff);
      wr(2, (dv >> 8) & 8'hff);
      wr(0, 0);
      wr(3, md);
      wr(4, sn);
      wr(5, sp);
   endtask

   task automatic wait_bound();
      int n = 0;
      do begin
         @(negedge clk); #1; n++;
      end while (!tx_bit_stb && n < 20000);
   endtask

   task automatic start_pulse();
      @(negedge clk); rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0;
   endtask

   task automatic measure(output int rk, output int tk, output int per, output int ntx);
      int t2 = -1;
      rk = -1; tk = -1; ntx = 0;
      for (int k = 0; k < 20000 && t2 < 0; k++) begin
         #1;
         if (rx_smp_stb && rk < 0) rk = k;
         if (tx_bit_stb) begin
            ntx++;
            if (tk < 0) tk = k; else t2 = k;
         end
         if (t2 < 0) @(negedge clk);
      end
      per = (t2 < 0 || tk < 0) ? -1 : t2 - tk;
   endtask

   initial begin
      int rk, tk, per, ntx;
      // R1: quiet during reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R1", int'(tx_bit_stb), 0);
         chk("R1", int'(rx_smp_stb), 0);
      end
      @(negedge clk); rst = 1'b0;
      measure(rk, tk, per, ntx);
      chk("R1", rk, 7);
      chk("R1", tk, 15);

      // table walk: R2, R3, R4, R6, R8
      for (int v = 0; v < NV; v++) begin
         cfg(V_DIV[v], V_MODE[v], V_SPAN[v], V_SP[v]);
         wait_bound();
         start_pulse();
         measure(rk, tk, per, ntx);
         chk((V_MODE[v] == 3) ? "R3" : "R2", rk, V_RK[v]);
         chk("R7", tk, V_TK[v]);
         chk((V_DIV[v] == 0) ? "R6" : "R4", per, V_PER[v]);
         chk("R8", ntx, 2);
      end

      // R10: start pulse in the cycle the bit-end strobe is due
      cfg(1, 0, 0, 0);
      wait_bound();
      start_pulse();
      for (int i = 0; i < 15; i++) @(negedge clk);
      rx_start = 1'b1;
      #1;
      chk("R10", int'(tx_bit_stb), 0);
      @(negedge clk); rx_start = 1'b0;
      measure(rk, tk, per, ntx);
      chk("R7", rk, 7);
      chk("R7", tk, 15);

      // R9: new divisor written mid-bit applies only from the next bit
      cfg(2, 0, 0, 0);
      wait_bound();
      wr(0, 8'h80); wr(1, 4); wr(2, 0); wr(0, 0);
      start_pulse();
      measure(rk, tk, per, ntx);
      chk("R9", rk, 15);
      chk("R9", tk, 31);
      chk("R9", per, 64);

      // R5: divisor writes with latch access clear are ignored
      cfg(1, 0, 0, 0);
      wait_bound();
      wait_bound();
      wr(1, 5); wr(2, 1);
      wait_bound();
      start_pulse();
      measure(rk, tk, per, ntx);
      chk("R5", tk, 15);
      chk("R5", per, 16);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule